// File: doc/BRIEF.md
# Stepper Drive Command Front End

This block sits between the isolated command inputs of a stepper power stage and its phase sequencer. It brings step, direction, enable, gate, current-modulation and fault inputs into the system clock domain. It turns each qualified rising step edge into a one-cycle strobe, and tags that strobe with the direction level captured on the same clock edge. A readiness timer holds the stage not-ready for a fixed delay after enable. The active-low ready output drops out at once on loss of enable or on a fault.

The current-modulation input is measured continuously. Its high time is divided by its period, and the result is given as an 8-bit current scale in which 255 means the phase current is off. A level held steady for longer than a timeout counts as a fixed 0% or 100%. The phase-current enable is active while the stage is ready and the scale is not at full off.

Two state machines carry the control. The readiness machine has the states `RD_OFF`, `RD_WAIT` and `RD_ON`. It moves from OFF to WAIT when enable is present with no fault, and from WAIT to ON when the delay counter expires. From any state it returns to OFF when enable is lost or a fault is present. The duty machine has the states `PM_IDLE`, `PM_RUN` and `PM_DIV`. It moves from IDLE to RUN on the first rising edge and from RUN to DIV on each later rising edge, which latches the period and high time. It moves from DIV back to RUN after eight serial divide steps, and from any state back to IDLE when the level has been steady too long.

Top module: `stepdrv_front`

## Requirements
- R1: A rising edge on `step_in` while the stage is ready and `gate_in` is high gives exactly one `step_stb` pulse, one clock wide, on the third rising clock edge after the input changes.
- R2: No strobe is produced for a rising step edge while `ready_n` is high or `gate_in` is low. A step input held high gives no further strobes.
- R3: `step_ccw` carries the direction level captured with each accepted edge: 0 for clockwise and 1 for counterclockwise. A direction change between steps leaves `step_ccw` unchanged.
- R4: `ready_n` goes low only after enable has been continuously present, with no fault, for the readiness delay of READY_US microseconds. Before that it stays high.
- R5: Deasserting `enable_in` or asserting `fault_in` forces `ready_n` high within three clocks. After either, the full delay restarts.
- R6: A `pwm_in` level held steady for longer than STUCK_US microseconds sets `cur_scale` to 0 when the level is low and to 255 when it is high.
- R7: For a periodic `pwm_in`, `cur_scale` becomes floor(256 × high / period) clock cycles, saturated at 255. It is updated within ten clocks after each rising edge that completes a period.
- R8: `coil_en` is high exactly when the stage is ready and `cur_scale` is not 255.
- R9: After reset, `ready_n` is 1, `step_stb` is 0, `step_ccw` is 0, `cur_scale` is 0 and `coil_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| step_in | input | 1 | Asynchronous step command, acted on at its rising edge |
| dir_in | input | 1 | Asynchronous direction level, 1 = counterclockwise |
| enable_in | input | 1 | Asynchronous power stage enable |
| gate_in | input | 1 | Asynchronous step gate, high lets steps through |
| pwm_in | input | 1 | Asynchronous current modulation, high = current off |
| fault_in | input | 1 | Asynchronous power stage fault |
| step_stb | output | 1 | One-cycle accepted step strobe |
| step_ccw | output | 1 | Direction of the latest accepted step |
| ready_n | output | 1 | Active-low readiness |
| coil_en | output | 1 | Phase current enable |
| cur_scale | output | 8 | Measured current-off fraction, 255 = off |

## Verification
The bench sends step edges just before and just after the readiness delay expires, with the gate low, and with the step input held high. A design that forgets to qualify steps, or that treats a level as an edge, would emit extra strobes. It toggles direction between pulses: a design that lets direction track the input would change `step_ccw` without a strobe. It raises a fault and drops enable once the stage is ready, then checks that the timer restarts from zero. A timer that only paused would bring ready back early. On the modulation input it uses three duty ratios and two stuck levels, which would expose an off-by-one in the period or high count, a missing saturation, or a stale scale after the input stops toggling.

// File: rtl/stepdrv_pkg.sv
package stepdrv_pkg;

    typedef enum logic [1:0] {
        RD_OFF  = 2'd0,
        RD_WAIT = 2'd1,
        RD_ON   = 2'd2
    } rd_state_t;

    typedef enum logic [1:0] {
        PM_IDLE = 2'd0,
        PM_RUN  = 2'd1,
        PM_DIV  = 2'd2
    } pm_state_t;

    localparam int SCALE_W = 8;

    function automatic int us_to_cycles(input int clk_hz, input int us);
        return (clk_hz / 1_000_000) * us;
    endfunction

endpackage

// File: rtl/stepdrv_sync.sv
module stepdrv_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/stepdrv_ready.sv
module stepdrv_ready
    import stepdrv_pkg::*;
#(
    parameter int DELAY_CYC = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic fault,
    output logic ready
);
    localparam int CNT_W = $clog2(DELAY_CYC + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DELAY_CYC - 1);

    rd_state_t        state, state_nx;
    logic [CNT_W-1:0] cnt;
    logic             go;

    assign go = en && !fault;

    always_comb begin
        state_nx = state;
        unique case (state)
            RD_OFF:  if (go) state_nx = RD_WAIT;
            RD_WAIT: if (!go) state_nx = RD_OFF;
                     else if (cnt == LAST) state_nx = RD_ON;
            RD_ON:   if (!go) state_nx = RD_OFF;
            default: state_nx = RD_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= RD_OFF;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            if (state == RD_WAIT && state_nx == RD_WAIT)
                cnt <= cnt + 1'b1;
            else
                cnt <= '0;
        end
    end

    always_comb begin
        ready = (state == RD_ON);
    end
endmodule

// File: rtl/stepdrv_pwm_meas.sv
module stepdrv_pwm_meas
    import stepdrv_pkg::*;
#(
    parameter int STUCK_CYC = 40000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lvl,
    output logic [SCALE_W-1:0] scale
);
    localparam int CW = $clog2(2 * STUCK_CYC + 2);
    localparam logic [CW-1:0] CMAX  = {CW{1'b1}};
    localparam logic [CW-1:0] STK_L = CW'(STUCK_CYC - 1);
    localparam logic [CW-1:0] STK_M = CW'(STUCK_CYC);

    pm_state_t     state, state_nx;
    logic          lvl_d, rise, any_edge, stuck;
    logic [CW-1:0] idle_cnt, per_cnt, hi_cnt, den, rem;
    logic [CW:0]   rem2;
    logic [7:0]    quo;
    logic [2:0]    bit_cnt;
    logic          sat, take;

    assign rise     = lvl && !lvl_d;
    assign any_edge = lvl ^ lvl_d;
    assign stuck    = !any_edge && (idle_cnt == STK_L);
    assign rem2     = {rem, 1'b0};
    assign take     = (rem2 >= {1'b0, den});

    // measurement counters, independent of the control state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_d    <= 1'b0;
            idle_cnt <= '0;
            per_cnt  <= '0;
            hi_cnt   <= '0;
        end else begin
            lvl_d <= lvl;
            if (any_edge)
                idle_cnt <= '0;
            else if (idle_cnt != STK_M)
                idle_cnt <= idle_cnt + 1'b1;
            if (rise) begin
                per_cnt <= CW'(1);
                hi_cnt  <= CW'(1);
            end else begin
                if (per_cnt != CMAX) per_cnt <= per_cnt + 1'b1;
                if (lvl && hi_cnt != CMAX) hi_cnt <= hi_cnt + 1'b1;
            end
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            PM_IDLE: if (rise) state_nx = PM_RUN;
            PM_RUN:  if (stuck) state_nx = PM_IDLE;
                     else if (rise) state_nx = PM_DIV;
            PM_DIV:  if (stuck) state_nx = PM_IDLE;
                     else if (bit_cnt == 3'd7) state_nx = PM_RUN;
            default: state_nx = PM_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= PM_IDLE;
            bit_cnt <= '0;
        end else begin
            state <= state_nx;
            if (state == PM_DIV) bit_cnt <= bit_cnt + 1'b1;
            else                 bit_cnt <= '0;
        end
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            den   <= '0;
            rem   <= '0;
            quo   <= '0;
            sat   <= 1'b0;
            scale <= '0;
        end else begin
            if (stuck) begin
                scale <= lvl ? 8'hFF : 8'h00;
            end else if (state == PM_RUN && rise) begin
                den <= per_cnt;
                rem <= hi_cnt;
                sat <= (hi_cnt >= per_cnt);
                quo <= '0;
            end else if (state == PM_DIV) begin
                rem <= take ? CW'(rem2 - {1'b0, den}) : rem2[CW-1:0];
                quo <= {quo[6:0], take};
                if (bit_cnt == 3'd7)
                    scale <= sat ? 8'hFF : {quo[6:0], take};
            end
        end
    end
endmodule

// File: rtl/stepdrv_front.sv
module stepdrv_front
    import stepdrv_pkg::*;
#(
    parameter int CLK_FREQ_HZ = 200_000_000,
    parameter int READY_US    = 500_000,
    parameter int STUCK_US    = 200
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               step_in,
    input  logic               dir_in,
    input  logic               enable_in,
    input  logic               gate_in,
    input  logic               pwm_in,
    input  logic               fault_in,
    output logic               step_stb,
    output logic               step_ccw,
    output logic               ready_n,
    output logic               coil_en,
    output logic [SCALE_W-1:0] cur_scale
);
    localparam int DELAY_CYC = us_to_cycles(CLK_FREQ_HZ, READY_US);
    localparam int STUCK_CYC = us_to_cycles(CLK_FREQ_HZ, STUCK_US);
    localparam int NSYNC     = 6;

    logic [NSYNC-1:0] raw, synced;
    logic step_s, dir_s, en_s, gate_s, pwm_s, fault_s;
    logic step_d, ready, accept;

    assign raw = {fault_in, pwm_in, gate_in, enable_in, dir_in, step_in};
    assign {fault_s, pwm_s, gate_s, en_s, dir_s, step_s} = synced;

    stepdrv_sync #(.W(NSYNC)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw), .q(synced)
    );

    stepdrv_ready #(.DELAY_CYC(DELAY_CYC)) u_ready (
        .clk(clk), .rst_n(rst_n), .en(en_s), .fault(fault_s), .ready(ready)
    );

    stepdrv_pwm_meas #(.STUCK_CYC(STUCK_CYC)) u_pwm (
        .clk(clk), .rst_n(rst_n), .lvl(pwm_s), .scale(cur_scale)
    );

    assign accept = step_s && !step_d && ready && gate_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_d   <= 1'b0;
            step_stb <= 1'b0;
            step_ccw <= 1'b0;
        end else begin
            step_d   <= step_s;
            step_stb <= accept;
            if (accept) step_ccw <= dir_s;
        end
    end

    always_comb begin
        ready_n = !ready;
        coil_en = ready && (cur_scale != 8'hFF);
    end
endmodule

// File: rtl/stepdrv_chk.sv
module stepdrv_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       step_stb,
    input logic       step_ccw,
    input logic       ready_n,
    input logic       coil_en,
    input logic [7:0] cur_scale,
    input logic       en_s,
    input logic       fault_s
);
    assert_stb_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
        step_stb |-> $past(ready_n) == 1'b0);

    assert_stb_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        step_stb |=> !step_stb);

    assert_dir_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step_ccw != $past(step_ccw)) |-> step_stb);

    assert_ready_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready_n) |-> ($past(en_s) && !$past(fault_s)));

    assert_ready_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_s || fault_s) |=> ready_n);

    assert_coil_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_n || cur_scale == 8'hFF) |-> !coil_en);
endmodule

bind stepdrv_front stepdrv_chk u_chk (
    .clk(clk), .rst_n(rst_n), .step_stb(step_stb), .step_ccw(step_ccw),
    .ready_n(ready_n), .coil_en(coil_en), .cur_scale(cur_scale),
    .en_s(en_s), .fault_s(fault_s)
);

// File: tb/sim_stepdrv_front.sv
module sim_stepdrv_front;
    localparam int DLY = 400;   // 200 cycles per us * 2 us

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic step_in = 0, dir_in = 0, enable_in = 0, gate_in = 0, pwm_in = 0, fault_in = 0;
    logic step_stb, step_ccw, ready_n, coil_en;
    logic [7:0] cur_scale;

    int checks = 0;
    int errors = 0;
    int stb_cnt = 0;
    int cyc = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    stepdrv_front #(.CLK_FREQ_HZ(200_000_000), .READY_US(2), .STUCK_US(2)) u0 (
        .clk(clk), .rst_n(rst_n), .step_in(step_in), .dir_in(dir_in),
        .enable_in(enable_in), .gate_in(gate_in), .pwm_in(pwm_in),
        .fault_in(fault_in), .step_stb(step_stb), .step_ccw(step_ccw),
        .ready_n(ready_n), .coil_en(coil_en), .cur_scale(cur_scale)
    );

    always @(negedge clk) begin
        if (step_stb) stb_cnt++;
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_step();
        step_in = 1; wait_n(5);
        step_in = 0; wait_n(5);
    endtask

    task automatic make_ready();
        enable_in = 1; fault_in = 0;
        wait_n(DLY + 10);
    endtask

    task automatic t_reset();
        wait_n(2);
        chk("R9 ready_n", ready_n, 1);
        chk("R9 step_stb", step_stb, 0);
        chk("R9 step_ccw", step_ccw, 0);
        chk("R9 cur_scale", cur_scale, 0);
        chk("R9 coil_en", coil_en, 0);
    endtask

    task automatic t_ready_delay();
        int s;
        gate_in = 1;
        enable_in = 1;
        wait_n(DLY - 100);
        chk("R4 still not ready", ready_n, 1);
        s = stb_cnt;
        pulse_step();
        chk("R2 step before ready ignored", stb_cnt - s, 0);
        wait_n(100);
        chk("R4 ready after delay", ready_n, 0);
        chk("R8 coil on when ready", coil_en, 1);
    endtask

    task automatic t_step_accept();
        int s;
        dir_in = 0;
        wait_n(4);
        s = stb_cnt;
        step_in = 1;
        wait_n(2);
        chk("R1 no strobe at 2 clocks", step_stb, 0);
        wait_n(1);
        chk("R1 strobe at 3rd clock", step_stb, 1);
        wait_n(1);
        chk("R1 strobe one cycle", step_stb, 0);
        wait_n(20);
        chk("R2 held high gives one strobe", stb_cnt - s, 1);
        chk("R3 clockwise", step_ccw, 0);
        step_in = 0; wait_n(5);
        gate_in = 0; wait_n(4);
        s = stb_cnt;
        pulse_step();
        chk("R2 gate low ignored", stb_cnt - s, 0);
        gate_in = 1; wait_n(4);
        s = stb_cnt;
        for (int k = 0; k < 3; k++) pulse_step();
        chk("R1 three pulses three strobes", stb_cnt - s, 3);
    endtask

    task automatic t_dir();
        dir_in = 1; wait_n(4);
        pulse_step();
        chk("R3 counterclockwise", step_ccw, 1);
        dir_in = 0; wait_n(20);
        chk("R3 dir change without step ignored", step_ccw, 1);
        pulse_step();
        chk("R3 back to clockwise", step_ccw, 0);
    endtask

    task automatic t_drop();
        int s;
        fault_in = 1;
        wait_n(3);
        chk("R5 fault drops ready", ready_n, 1);
        s = stb_cnt;
        pulse_step();
        chk("R2 step during fault ignored", stb_cnt - s, 0);
        fault_in = 0;
        wait_n(DLY - 100);
        chk("R5 delay restarted after fault", ready_n, 1);
        wait_n(110);
        chk("R5 ready back after fault", ready_n, 0);
        enable_in = 0;
        wait_n(3);
        chk("R5 enable loss drops ready", ready_n, 1);
        chk("R8 coil off when not ready", coil_en, 0);
        make_ready();
        chk("R4 ready after re-enable", ready_n, 0);
    endtask

    task automatic drive_pwm(input int hi, input int per, input int n);
        for (int k = 0; k < n; k++) begin
            pwm_in = 1; wait_n(hi);
            pwm_in = 0; wait_n(per - hi);
        end
    endtask

    task automatic t_pwm();
        pwm_in = 1; wait_n(500);
        chk("R6 stuck high gives 255", cur_scale, 255);
        chk("R8 coil off at full off", coil_en, 0);
        pwm_in = 0; wait_n(500);
        chk("R6 stuck low gives 0", cur_scale, 0);
        chk("R8 coil on at zero", coil_en, 1);
        drive_pwm(25, 100, 5);
        chk("R7 duty 25 percent", cur_scale, 64);
        drive_pwm(50, 100, 5);
        chk("R7 duty 50 percent", cur_scale, 128);
        drive_pwm(75, 100, 5);
        chk("R7 duty 75 percent", cur_scale, 192);
        chk("R8 coil on at partial duty", coil_en, 1);
        drive_pwm(30, 60, 5);
        chk("R7 duty 30 of 60", cur_scale, 128);
        pwm_in = 0; wait_n(500);
        chk("R6 stops toggling gives 0", cur_scale, 0);
    endtask

    initial begin
        wait_n(3);
        t_reset();
        rst_n = 1;
        wait_n(3);
        t_reset();
        t_ready_delay();
        t_step_accept();
        t_dir();
        t_drop();
        t_pwm();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule